// File: doc/BRIEF.md
# Bus Control Register with I/O Width Detection

This block is a host-visible configuration register for a bus-mastering device. It holds a burst-read enable and a flag that records whether the device's I/O space is laid out for 16-bit word accesses or 32-bit double-word accesses. The width flag cannot be written through the register. Instead, the block watches host I/O writes, and the first 32-bit write to the data-port offset moves the device into double-word mode. From then on only a hardware reset returns it to word mode.

The block separates three reset domains. Hardware reset brings every stored field to its initial value. Software reset and stop requests leave the whole register untouched. A combinational read port returns the 32-bit register image, which includes fixed constant fields. The block has two helper outputs. `word_mode` tells downstream I/O decoding which resource spacing to use. `burst_ok` tells a bus master whether the memory read now in progress may be linearly burst, which means an address phase only on the first transfer of the tenure.

The width flag is kept by a two-state machine. State `ST_WORD` is entered on hardware reset. It takes transition `DP_DWORD_WR` to `ST_DWORD` when a 32-bit I/O write hits the data-port offset. Otherwise it follows transition `WORD_HOLD` back to itself. State `ST_DWORD` has only transition `DWORD_HOLD` back to itself. Software reset, stop and register writes take this transition too. Hardware reset leaves it through transition `HW_CLEAR` to `ST_WORD`.

Top module: `buscfg_ctrl`

## Requirements
- R1: In the cycle after `hw_rst` is sampled high, `reg_rdata` is 32'h0000_2100, `word_mode` is 1 and `burst_ok` is 0.
- R2: An I/O write sampled with `io_wr`=1, `io_dword`=1 and `io_off`=5'h10 sets image bit 7 from the next cycle.
- R3: An I/O write that is 16-bit (`io_dword`=0), or that is 32-bit to any offset other than 5'h10, leaves image bit 7 unchanged.
- R4: A register write (`reg_wr`=1) never changes image bit 7, whatever `reg_wdata[7]` holds.
- R5: Once image bit 7 is 1, it stays 1 through software reset, stop and register writes, until a hardware reset.
- R6: The image always reads bits 15:11 = 5'b00100 and bit 8 = 1. Bits 31:16, bit 9 and bits 5:0 always read 0. Register writes change none of these bits.
- R7: Image bit 6 (burst-read enable) takes `reg_wdata[6]` on a register write and is cleared by hardware reset. Software reset and stop neither clear it nor block a write in the same cycle.
- R8: Image bit 10 takes `reg_wdata[10]` on a register write, is cleared by hardware reset, and is unaffected by software reset and stop.
- R9: `burst_ok` is 1 exactly when image bit 6, `mem_rd` and `buf_data_rd` are all 1, in the same cycle. A non-buffer read such as a descriptor or initialization access is never burst.
- R10: `word_mode` is always the inverse of image bit 7.
- R11: Hardware reset takes priority over a register write and over a data-port 32-bit I/O write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset request (no effect on this register) |
| stop_req | input | 1 | Stop request (no effect on this register) |
| io_wr | input | 1 | Host I/O write strobe |
| io_off | input | IO_OFF_W | Offset of the I/O write from the I/O base |
| io_dword | input | 1 | I/O write is a 32-bit access |
| reg_wr | input | 1 | Write strobe for this register |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register image |
| mem_rd | input | 1 | Bus master is performing a memory read |
| buf_data_rd | input | 1 | The current access is buffer data (not descriptor or init) |
| burst_ok | output | 1 | Current memory read may be linearly burst |
| word_mode | output | 1 | I/O resources use 16-bit spacing |

## Verification
The assertions assume that `hw_rst` is high at the first clock edge. This means the stored fields and the width state machine start from known values before any property looks back one cycle. They also assume that every strobe and qualifier is a clean 0 or 1 at each sampled edge. The bench meets both conditions: it holds `hw_rst` high from time zero through the first edge, and it drives every input to a defined level at each falling edge. It drives the data-port offset only with the intended access sizes. It combines software reset and stop with writes only in the cycles where the requirements define the result.

// File: rtl/buscfg_pkg.sv
package buscfg_pkg;

    typedef enum logic {
        ST_WORD  = 1'b0,
        ST_DWORD = 1'b1
    } width_state_e;

    localparam int BIT_BRE   = 6;
    localparam int BIT_DW    = 7;
    localparam int BIT_ONE   = 8;
    localparam int BIT_ZERO9 = 9;
    localparam int BIT_RSV10 = 10;
    localparam int FIX_LO    = 11;
    localparam int FIX_HI    = 15;
    localparam int FIX_W     = FIX_HI - FIX_LO + 1;
    localparam logic [FIX_W-1:0] FIX_PAT = 5'b00100;

endpackage

// File: rtl/iowidth_fsm.sv
module iowidth_fsm
    import buscfg_pkg::*;
(
    input  logic clk,
    input  logic hw_rst,
    input  logic soft_evt,
    input  logic dp_dword_wr,
    output logic dw_mode
);

    width_state_e state_q, state_d;

    // state register: hardware reset is the only way back to word mode
    always_ff @(posedge clk) begin
        if (hw_rst) state_q <= ST_WORD;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WORD: begin
                if (dp_dword_wr)   state_d = ST_DWORD;
                else if (soft_evt) state_d = ST_WORD;
                else               state_d = ST_WORD;
            end
            ST_DWORD: begin
                state_d = ST_DWORD;
            end
            default: state_d = ST_WORD;
        endcase
    end

    // outputs
    always_comb begin
        dw_mode = 1'b0;
        unique case (state_q)
            ST_WORD:  dw_mode = 1'b0;
            ST_DWORD: dw_mode = 1'b1;
            default:  dw_mode = 1'b0;
        endcase
    end

endmodule

// File: rtl/burst_ctl.sv
module burst_ctl (
    input  logic clk,
    input  logic hw_rst,
    input  logic soft_evt,
    input  logic wr_en,
    input  logic bre_in,
    input  logic rsv10_in,
    input  logic mem_rd,
    input  logic buf_data_rd,
    output logic bre,
    output logic rsv10,
    output logic burst_ok
);

    logic bre_q, rsv10_q;

    // a write wins over a soft event; a soft event alone holds the fields
    always_ff @(posedge clk) begin
        if (hw_rst) begin
            bre_q   <= 1'b0;
            rsv10_q <= 1'b0;
        end else if (wr_en) begin
            bre_q   <= bre_in;
            rsv10_q <= rsv10_in;
        end else if (soft_evt) begin
            bre_q   <= bre_q;
            rsv10_q <= rsv10_q;
        end
    end

    assign bre      = bre_q;
    assign rsv10    = rsv10_q;
    // only buffer-data memory reads may burst
    assign burst_ok = bre_q & mem_rd & buf_data_rd;

endmodule

// File: rtl/rd_image.sv
module rd_image
    import buscfg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              dw_mode,
    input  logic              bre,
    input  logic              rsv10,
    output logic [DATA_W-1:0] image
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == BIT_BRE) begin : g_bre
            assign image[i] = bre;
        end else if (i == BIT_DW) begin : g_dw
            assign image[i] = dw_mode;
        end else if (i == BIT_ONE) begin : g_one
            assign image[i] = 1'b1;
        end else if (i == BIT_RSV10) begin : g_rsv
            assign image[i] = rsv10;
        end else if (i >= FIX_LO && i <= FIX_HI) begin : g_fix
            assign image[i] = FIX_PAT[i-FIX_LO];
        end else begin : g_zero
            assign image[i] = 1'b0;
        end
    end

endmodule

// File: rtl/buscfg_ctrl.sv
module buscfg_ctrl
    import buscfg_pkg::*;
#(
    parameter int                  DATA_W   = 32,
    parameter int                  IO_OFF_W = 5,
    parameter logic [IO_OFF_W-1:0] DP_OFF   = 'h10
) (
    input  logic                clk,
    input  logic                hw_rst,
    input  logic                sw_rst,
    input  logic                stop_req,
    input  logic                io_wr,
    input  logic [IO_OFF_W-1:0] io_off,
    input  logic                io_dword,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                mem_rd,
    input  logic                buf_data_rd,
    output logic                burst_ok,
    output logic                word_mode
);

    localparam int HI_W = DATA_W - FIX_HI - 1;

    logic soft_evt;
    logic dp_dword_wr;
    logic dw_mode;
    logic bre, rsv10;

    assign soft_evt    = sw_rst | stop_req;
    assign dp_dword_wr = io_wr & io_dword & (io_off == DP_OFF);

    // write data bits with no storage behind them
    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[DATA_W-1:BIT_RSV10+1],
                            reg_wdata[BIT_RSV10-1:BIT_BRE+1],
                            reg_wdata[BIT_BRE-1:0], HI_W[0]};

    iowidth_fsm u_fsm (
        .clk         (clk),
        .hw_rst      (hw_rst),
        .soft_evt    (soft_evt),
        .dp_dword_wr (dp_dword_wr),
        .dw_mode     (dw_mode)
    );

    burst_ctl u_burst (
        .clk         (clk),
        .hw_rst      (hw_rst),
        .soft_evt    (soft_evt),
        .wr_en       (reg_wr),
        .bre_in      (reg_wdata[BIT_BRE]),
        .rsv10_in    (reg_wdata[BIT_RSV10]),
        .mem_rd      (mem_rd),
        .buf_data_rd (buf_data_rd),
        .bre         (bre),
        .rsv10       (rsv10),
        .burst_ok    (burst_ok)
    );

    rd_image #(.DATA_W(DATA_W)) u_img (
        .dw_mode (dw_mode),
        .bre     (bre),
        .rsv10   (rsv10),
        .image   (reg_rdata)
    );

    assign word_mode = ~dw_mode;

endmodule

// File: rtl/buscfg_ctrl_chk.sv
module buscfg_ctrl_chk #(
    parameter int                  DATA_W   = 32,
    parameter int                  IO_OFF_W = 5,
    parameter logic [IO_OFF_W-1:0] DP_OFF   = 'h10
) (
    input logic                clk,
    input logic                hw_rst,
    input logic                sw_rst,
    input logic                stop_req,
    input logic                io_wr,
    input logic [IO_OFF_W-1:0] io_off,
    input logic                io_dword,
    input logic                reg_wr,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic                mem_rd,
    input logic                buf_data_rd,
    input logic                burst_ok,
    input logic                word_mode
);

    logic hit;
    assign hit = io_wr && io_dword && (io_off == DP_OFF);

    p_dp_set_r2: assert property (@(posedge clk) disable iff (hw_rst)
        hit |=> reg_rdata[7]);

    p_other_hold_r3: assert property (@(posedge clk) disable iff (hw_rst)
        (!reg_rdata[7] && !hit) |=> !reg_rdata[7]);

    p_sticky_r5: assert property (@(posedge clk) disable iff (hw_rst)
        reg_rdata[7] |=> reg_rdata[7]);

    p_fixed_r6: assert property (@(posedge clk) disable iff (hw_rst)
        1'b1 |-> (reg_rdata[15:11] == 5'b00100 && reg_rdata[8] &&
                  !reg_rdata[9] && reg_rdata[5:0] == 6'd0 &&
                  reg_rdata[DATA_W-1:16] == '0));

    p_soft_hold_r7: assert property (@(posedge clk) disable iff (hw_rst)
        ((sw_rst || stop_req) && !reg_wr) |=> ($stable(reg_rdata[6]) && $stable(reg_rdata[10])));

    p_burst_r9: assert property (@(posedge clk) disable iff (hw_rst)
        burst_ok |-> (mem_rd && buf_data_rd && reg_rdata[6]));

    p_wmode_r10: assert property (@(posedge clk) disable iff (hw_rst)
        word_mode != reg_rdata[7]);

endmodule

bind buscfg_ctrl buscfg_ctrl_chk #(
    .DATA_W(DATA_W), .IO_OFF_W(IO_OFF_W), .DP_OFF(DP_OFF)
) u_chk (
    .clk(clk), .hw_rst(hw_rst), .sw_rst(sw_rst), .stop_req(stop_req),
    .io_wr(io_wr), .io_off(io_off), .io_dword(io_dword), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata), .mem_rd(mem_rd), .buf_data_rd(buf_data_rd),
    .burst_ok(burst_ok), .word_mode(word_mode)
);

// File: tb/buscfg_ctrl_test.sv
module buscfg_ctrl_test;

    logic        clk = 1'b0;
    logic        hw_rst = 1'b1;
    logic        sw_rst = 1'b0;
    logic        stop_req = 1'b0;
    logic        io_wr = 1'b0;
    logic [4:0]  io_off = '0;
    logic        io_dword = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd = 1'b0;
    logic        buf_data_rd = 1'b0;
    logic        burst_ok;
    logic        word_mode;

    always #5 clk = ~clk;

    buscfg_ctrl uut (
        .clk(clk), .hw_rst(hw_rst), .sw_rst(sw_rst), .stop_req(stop_req),
        .io_wr(io_wr), .io_off(io_off), .io_dword(io_dword),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd(mem_rd), .buf_data_rd(buf_data_rd),
        .burst_ok(burst_ok), .word_mode(word_mode)
    );

    typedef struct {
        logic [31:0] rdata;
        logic        wmode;
        logic        bok;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic m_dw = 0, m_bre = 0, m_b10 = 0;

    function automatic logic [31:0] image_of(logic dw, logic bre, logic b10);
        return {16'h0, 5'b00100, b10, 1'b0, 1'b1, dw, bre, 6'b0};
    endfunction

    // driver: apply one cycle of stimulus and queue the expected result
    task automatic step(input logic hr, input logic sr, input logic st,
                        input logic iw, input logic [4:0] off, input logic dw32,
                        input logic rw, input logic [31:0] wd,
                        input logic mr, input logic bd, input string tag);
        exp_t e;
        @(negedge clk);
        hw_rst = hr; sw_rst = sr; stop_req = st;
        io_wr = iw; io_off = off; io_dword = dw32;
        reg_wr = rw; reg_wdata = wd; mem_rd = mr; buf_data_rd = bd;
        if (hr) begin
            m_dw = 0; m_bre = 0; m_b10 = 0;
        end else begin
            if (iw && dw32 && off == 5'h10) m_dw = 1;
            if (rw) begin m_bre = wd[6]; m_b10 = wd[10]; end
        end
        e.rdata = image_of(m_dw, m_bre, m_b10);
        e.wmode = ~m_dw;
        e.bok   = m_bre & mr & bd;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (reg_rdata !== e.rdata || word_mode !== e.wmode || burst_ok !== e.bok) begin
                    errors++;
                    $display("FAIL %s: rdata=%h wmode=%b bok=%b expected rdata=%h wmode=%b bok=%b",
                             e.tag, reg_rdata, word_mode, burst_ok, e.rdata, e.wmode, e.bok);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(1,0,0, 0,5'h00,0, 0,32'h0,        0,0, "R1 reset image");
        step(0,0,0, 0,5'h00,0, 0,32'h0,        0,0, "R1 idle after reset");
        step(0,0,0, 0,5'h00,0, 1,32'hFFFF_FFFF,0,0, "R4 R6 R7 R8 write all ones");
        step(0,0,0, 1,5'h10,0, 0,32'h0,        0,0, "R3 16-bit write to data port");
        step(0,0,0, 1,5'h14,1, 0,32'h0,        0,0, "R3 32-bit write to other offset");
        step(0,0,0, 0,5'h00,0, 0,32'h0,        1,1, "R9 buffer read bursts");
        step(0,0,0, 0,5'h00,0, 0,32'h0,        1,0, "R9 descriptor read no burst");
        step(0,0,0, 0,5'h00,0, 0,32'h0,        0,1, "R9 not a memory read");
        step(0,0,0, 1,5'h10,1, 0,32'h0,        0,0, "R2 R10 dword data-port write");
        step(0,0,0, 0,5'h00,0, 1,32'h0,        0,0, "R4 R6 write zeros keeps dword");
        step(0,1,0, 0,5'h00,0, 0,32'h0,        0,0, "R5 software reset");
        step(0,0,1, 0,5'h00,0, 0,32'h0,        0,0, "R5 stop");
        step(0,1,0, 0,5'h00,0, 1,32'h0000_0440,1,1, "R7 R8 write with software reset");
        step(0,1,1, 0,5'h00,0, 0,32'h0,        1,1, "R7 R8 soft events hold");
        step(1,0,0, 1,5'h10,1, 1,32'hFFFF_FFFF,0,0, "R11 reset beats writes");
        step(0,0,0, 0,5'h00,0, 0,32'h0,        1,1, "R9 R1 no burst after reset");
        step(0,0,0, 1,5'h10,1, 0,32'h0,        0,0, "R2 dword write again");
        step(0,0,0, 0,5'h00,0, 0,32'h0,        0,0, "R5 R10 sticky idle");
        @(negedge clk);
        io_wr = 0; reg_wr = 0; mem_rd = 0; buf_data_rd = 0;
        while (exp_q.size() > 0) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule